// File: doc/BRIEF.md
# Paged Address Extension Mapper

This block widens a 16-bit processor address into a 24-bit physical memory address. The processor address space is cut into sixteen windows of 4096 bytes. The top nibble of each processor address picks one of sixteen table slots. Each slot holds a 12-bit frame number. That frame number takes the place of the nibble. The low twelve address bits go through unchanged as the byte offset inside the window.

Software sets up the table through a small register port. The port has a slot select, a write strobe, a write data bus and a read data bus that answers combinationally. A single enable input turns the mapper off. When it is off, the processor address is zero-extended to 24 bits. After reset every slot holds its own index, so the first 64 KiB are mapped one to one. Translation itself contains no register. Only the table is clocked.

Top module: `addr_window_mapper`

## Requirements
- R1: While `map_en` is 1, `phys_addr[11:0]` equals `cpu_addr[11:0]` in the same cycle.
- R2: While `map_en` is 1, `phys_addr[23:12]` equals the frame number stored in slot `cpu_addr[15:12]`, in the same cycle (combinational).
- R3: While `map_en` is 0, `phys_addr` equals `{8'h00, cpu_addr}` whatever the table holds.
- R4: After a clock edge with `rst_n` low, slot i holds frame number i for every i from 0 to 15.
- R5: A clock edge with `rst_n` high and `cfg_we` high stores `cfg_wdata` into slot `cfg_sel`. Translations from the next cycle on use the new value. Before that edge the old value is used.
- R6: A write changes only the selected slot; all other slots keep their frame numbers.
- R7: `cfg_rdata` always shows the frame number stored in slot `cfg_sel`, combinationally.
- R8: Reset has priority over a write presented on the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for table writes |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_addr | input | 16 | Processor address |
| map_en | input | 1 | 1 = translate through table, 0 = zero-extend |
| cfg_sel | input | 4 | Table slot for write and readback |
| cfg_we | input | 1 | Write strobe |
| cfg_wdata | input | 12 | Frame number to write |
| cfg_rdata | output | 12 | Frame number held in slot `cfg_sel` |
| phys_addr | output | 24 | Physical address |

## Verification
A corrupted or wrongly written slot is invisible until an address with that nibble is translated or the slot is read back. At that point it shows in the same cycle as a wrong upper field of `phys_addr` or a wrong `cfg_rdata`. The bench therefore sweeps all sixteen nibbles and reads back all sixteen slots after every write phase. A write that lands on the wrong slot, or lands one cycle late, is caught on the first compare after the write edge. The bench also checks that the enable bypass hides table contents entirely.

// File: rtl/awm_pkg.sv
// Package awm_pkg
// Shared widths and types for the address window mapper.
// Assumes the processor address splits into a window index and an offset.
package awm_pkg;
    localparam int CPU_AW  = 16;
    localparam int OFS_W   = 12;
    localparam int FRAME_W = 12;
    localparam int IDX_W   = CPU_AW - OFS_W;
    localparam int SLOTS   = 1 << IDX_W;
    localparam int PHYS_AW = FRAME_W + OFS_W;

    typedef logic [FRAME_W-1:0] frame_t;
    typedef logic [IDX_W-1:0]   idx_t;
endpackage

// File: rtl/awm_table.sv
// Module awm_table
// Register file of frame numbers, one per window.
// Synchronous active-low reset loads the identity mapping (slot i -> i).
// Assumes FRAME_W >= IDX_W so the identity value fits.
// It has one write port and two combinational read ports:
// one for translation and one for the configuration readback.
module awm_table
    import awm_pkg::*;
#(
    parameter int N_SLOT = SLOTS,
    parameter int SEL_W  = IDX_W,
    parameter int DW     = FRAME_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [SEL_W-1:0] wsel,
    input  logic [DW-1:0]    wdata,
    input  logic [SEL_W-1:0] xsel,
    output logic [DW-1:0]    xdata,
    input  logic [SEL_W-1:0] rsel,
    output logic [DW-1:0]    rdata
);
    logic [DW-1:0] slot_q [N_SLOT];

    genvar g;
    generate
        for (g = 0; g < N_SLOT; g++) begin : g_slot
            // Per slot: reset to identity index, else capture on a matching write.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    slot_q[g] <= DW'(g);
                else if (we && (wsel == SEL_W'(g)))
                    slot_q[g] <= wdata;
            end
        end
    endgenerate

    // Translation read port.
    always_comb xdata = slot_q[xsel];

    // Configuration readback port.
    always_comb rdata = slot_q[rsel];

    // R8 / R4: after a reset edge every slot holds its own index.
    genvar a;
    generate
        for (a = 0; a < N_SLOT; a++) begin : g_chk
            a_r4_identity_after_reset: assert property (
                @(posedge clk) !rst_n |=> (slot_q[a] == DW'(a)));
            // R6: a slot not addressed by a write keeps its value.
            a_r6_unselected_stable: assert property (
                @(posedge clk) disable iff (!rst_n)
                !(we && wsel == SEL_W'(a)) |=> $stable(slot_q[a]));
        end
    endgenerate
endmodule

// File: rtl/awm_xlate.sv
// Module awm_xlate
// Combinational address composer.
// With enable high it joins the frame number and the offset.
// With enable low it zero-extends the processor address.
// Assumes the frame comes from the table slot chosen by the index bits.
module awm_xlate
    import awm_pkg::*;
(
    input  logic [CPU_AW-1:0]  addr,
    input  logic               en,
    input  frame_t             frame,
    output logic [PHYS_AW-1:0] paddr
);
    // Choose between mapped and bypass address.
    always_comb begin
        if (en)
            paddr = {frame, addr[OFS_W-1:0]};
        else
            paddr = PHYS_AW'(addr);
    end

    // R1: the offset passes through unchanged in both modes.
    a_r1_offset_pass: assert final (paddr[OFS_W-1:0] == addr[OFS_W-1:0]);
    // R3: bypass has zero upper bits above the processor address.
    a_r3_bypass_zero: assert final (en || paddr[PHYS_AW-1:CPU_AW] == '0);
endmodule

// File: rtl/addr_window_mapper.sv
// Module addr_window_mapper (top)
// Extends a 16-bit processor address to 24 bits through a 16-slot table
// of 12-bit frame numbers that software can program.
// Only the table writes are clocked; translation is combinational.
// Assumes a synchronous active-low reset.
module addr_window_mapper
    import awm_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [CPU_AW-1:0]  cpu_addr,
    input  logic               map_en,
    input  logic [IDX_W-1:0]   cfg_sel,
    input  logic               cfg_we,
    input  logic [FRAME_W-1:0] cfg_wdata,
    output logic [FRAME_W-1:0] cfg_rdata,
    output logic [PHYS_AW-1:0] phys_addr
);
    frame_t xl_frame;
    idx_t   win_idx;

    // Window index taken from the top address bits.
    always_comb win_idx = cpu_addr[CPU_AW-1:OFS_W];

    awm_table u_table (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (cfg_we),
        .wsel  (cfg_sel),
        .wdata (cfg_wdata),
        .xsel  (win_idx),
        .xdata (xl_frame),
        .rsel  (cfg_sel),
        .rdata (cfg_rdata)
    );

    awm_xlate u_xlate (
        .addr  (cpu_addr),
        .en    (map_en),
        .frame (xl_frame),
        .paddr (phys_addr)
    );

    // R5: a write is visible at readback on the next cycle if the select is held.
    a_r5_write_visible: assert property (
        @(posedge clk) disable iff (!rst_n)
        (cfg_we && !$isunknown(cfg_sel)) ##1 (rst_n && $stable(cfg_sel))
        |-> cfg_rdata == $past(cfg_wdata));
    // R2: the mapped upper bits equal the readback when both select the same slot.
    a_r2_frame_matches: assert property (
        @(posedge clk) disable iff (!rst_n)
        (map_en && cfg_sel == win_idx) |-> phys_addr[PHYS_AW-1:OFS_W] == cfg_rdata);
endmodule

// File: tb/tb_addr_window_mapper.sv
module tb_addr_window_mapper;
    logic        clk = 0;
    logic        rst_n;
    logic [15:0] cpu_addr;
    logic        map_en;
    logic [3:0]  cfg_sel;
    logic        cfg_we;
    logic [11:0] cfg_wdata;
    logic [11:0] cfg_rdata;
    logic [23:0] phys_addr;

    int n_chk = 0;
    int n_bad = 0;
    int model [16];   // reference table

    always #10 clk = ~clk;   // 50 MHz

    addr_window_mapper dut (.*);

    // Apply clock edge to the reference model with the same inputs.
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 16; i++) model[i] = i;
        end else if (cfg_we) begin
            model[cfg_sel] = cfg_wdata;
        end
    end

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Compare outputs against the model for one address (sampled mid-cycle).
    task automatic probe(string req, logic [15:0] a, logic en);
        logic [23:0] e;
        cpu_addr = a; map_en = en;
        #1;
        e = en ? {model[a[15:12]][11:0], a[11:0]} : {8'h00, a};
        chk(req, phys_addr, e);
    endtask

    task automatic sweep(string req, logic en);
        for (int i = 0; i < 16; i++) probe(req, {i[3:0], 12'h5A3 ^ i[11:0]}, en);
    endtask

    task automatic readback(string req);
        for (int i = 0; i < 16; i++) begin
            cfg_sel = i[3:0]; #1;
            chk(req, cfg_rdata, model[i]);
        end
    endtask

    task automatic wr(logic [3:0] s, logic [11:0] d);
        @(negedge clk);
        cfg_sel = s; cfg_wdata = d; cfg_we = 1;
        @(negedge clk);
        cfg_we = 0;
    endtask

    // Every-clock comparison of the configured slot.
    always @(negedge clk) if (rst_n === 1'b1) chk("R7", cfg_rdata, model[cfg_sel]);

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        rst_n = 0; cpu_addr = 0; map_en = 1; cfg_sel = 0; cfg_we = 0; cfg_wdata = 0;
        repeat (2) @(posedge clk);
        @(negedge clk); rst_n = 1;
        readback("R4");
        sweep("R2", 1);
        probe("R1", 16'h3FFF, 1);
        probe("R1", 16'hF000, 1);

        wr(4'h3, 12'hABC);
        wr(4'hF, 12'hFFF);
        wr(4'h0, 12'h800);
        readback("R6");
        sweep("R2", 1);
        sweep("R3", 0);
        probe("R3", 16'hFFFF, 0);

        // R5 timing: the old value is held until the edge, the new one is used after it.
        @(negedge clk);
        cfg_sel = 4'h7; cfg_wdata = 12'h123; cfg_we = 1;
        cpu_addr = 16'h7456; map_en = 1; #1;
        chk("R5", phys_addr, 24'h007456);
        @(negedge clk); cfg_we = 0; #1;
        chk("R5", phys_addr, 24'h123456);

        // R8: reset beats a simultaneous write.
        @(negedge clk);
        rst_n = 0; cfg_sel = 4'h9; cfg_wdata = 12'h777; cfg_we = 1;
        @(negedge clk);
        rst_n = 1; cfg_we = 0;
        cfg_sel = 4'h9; #1;
        chk("R8", cfg_rdata, 12'h009);
        readback("R4");

        // Back-to-back writes to every slot, then full sweep.
        for (int i = 0; i < 16; i++) begin
            @(negedge clk);
            cfg_sel = i[3:0]; cfg_wdata = 12'hC00 + i[11:0] * 12'h011; cfg_we = 1;
        end
        @(negedge clk); cfg_we = 0;
        readback("R5");
        sweep("R2", 1);

        @(negedge clk);
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule